// File: doc/BRIEF.md
# Hash-Based Queue Distributor

The distributor sits at the end of a receive classification path and turns a 64-bit flow hash into a 24-bit destination queue number. Software programs two words. The hash command word selects how far the hash is shifted right, how many queues the traffic spreads over, and whether the upstream hash was built from an order-independent key. The queue base word gives the first queue of the range. Each frame's hash arrives on a valid/ready stream. One cycle after it is accepted, the queue number appears on an output stream that holds its value while the consumer stalls.

The spread count is stored as count minus one, so the low field of the command word acts directly as an AND mask on the shifted hash. That masked value is added to the base. When the command word is all zeros, the mask is zero and every frame lands on the base queue, which is how hashing is switched off. A configuration error output reports a base outside 1 to 2^24-1, or a mask that is not one less than a power of two.

Top module: `flowq_spread`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, sym_mode is 0 and cfg_err is 1, because the queue base resets to zero.
- R2: A write with cfg_addr 0 loads the hash command word. Bits 29:24 give a right-shift amount S (0 to 63) and bits 23:0 give a mask M. A write with cfg_addr 1 loads the 32-bit queue base word B. For an accepted hash H, out_qid = (B[23:0] + ((H >> S)[23:0] & M)) mod 2^24.
- R3: With S equal to 0, the 24 least significant bits of the hash are used unchanged, before masking.
- R4: When the hash command word is 0, every accepted frame gets out_qid equal to B[23:0], whatever the hash.
- R5: Bit 30 of the hash command word appears on sym_mode from the cycle after the write and has no effect on out_qid.
- R6: cfg_err is 1 when B is 0, when B[31:24] is nonzero, or when M+1 is not a power of two (M & (M+1) nonzero in 24 bits). Otherwise cfg_err is 0.
- R7: A hash accepted at a clock edge (in_valid and in_ready both high) produces out_valid high with its queue number after that same edge. With no new input, an output taken by out_ready leaves out_valid low after the edge.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_valid and out_qid keep their values.
- R9: The sum of base and masked hash wraps modulo 2^24. For example, base 1 plus masked value 0xFFFFFF gives queue 0.
- R10: Bit 31 of the hash command word is reserved and has no effect on out_qid, sym_mode or cfg_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the hash command word, 1 selects the queue base word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_err | output | 1 | Configuration error flag |
| sym_mode | output | 1 | Symmetric-key mode from the command word |
| in_valid | input | 1 | Hash input valid |
| in_ready | output | 1 | Hash input ready |
| in_hash | input | 64 | Flow hash of the frame |
| out_valid | output | 1 | Queue number valid |
| out_ready | input | 1 | Consumer ready |
| out_qid | output | 24 | Destination queue number |

## Verification
The bench builds the block with its default parameters: a 64-bit hash, 24-bit queue numbers and a 6-bit shift field. With these values the shift extremes of 0, 32 and 63 can be tested, and so can the full 24-bit mask, where the sum wraps past 2^24. Because the queue number keeps its full 24-bit width, both the carry-out of the base addition and the upper base bits that must raise the error flag can be observed at the ports. The 6-bit shift field leaves bit 30 free for the symmetric flag, so the bench can show that this flag and the reserved bit 31 change nothing in the queue result.

// File: rtl/flowq_pkg.sv
// Package: shared constants and register selector for the queue distributor.
// Assumes the command word is 32 bits with the mode flag above the shift field.
package flowq_pkg;
    localparam int CMD_W     = 32;
    localparam int SHIFT_POS = 24;
    localparam int SYM_POS   = 30;

    typedef enum logic {
        SEL_HASHCMD = 1'b0,
        SEL_QBASE   = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/flowq_cfg_regs.sv
// Module: configuration store for the distributor.
// Holds the command and base words, splits them into fields and checks them.
// Assumes QID_W <= SHIFT_POS and SHIFT_POS + SHIFT_W <= SYM_POS.
module flowq_cfg_regs
    import flowq_pkg::*;
#(
    parameter int QID_W   = 24,
    parameter int SHIFT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [CMD_W-1:0]   cfg_wdata,
    output logic [SHIFT_W-1:0] shift_amt,
    output logic [QID_W-1:0]   spread_mask,
    output logic [QID_W-1:0]   qbase,
    output logic               cmd_zero,
    output logic               sym_mode,
    output logic               cfg_err
);
    localparam int BASE_HI_W = CMD_W - QID_W;

    logic [SHIFT_W-1:0] shift_q;
    logic [QID_W-1:0]   mask_q;
    logic               sym_q;
    logic               rsvd_q_unused;
    logic [CMD_W-1:0]   base_q;
    logic [QID_W-1:0]   mask_inc;
    logic               gap_unused;

    // Purpose: capture command word fields and base word on software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q       <= '0;
            mask_q        <= '0;
            sym_q         <= 1'b0;
            rsvd_q_unused <= 1'b0;
            base_q        <= '0;
        end else if (cfg_we) begin
            if (cfg_sel_e'(cfg_addr) == SEL_HASHCMD) begin
                shift_q       <= cfg_wdata[SHIFT_POS +: SHIFT_W];
                mask_q        <= cfg_wdata[QID_W-1:0];
                sym_q         <= cfg_wdata[SYM_POS];
                rsvd_q_unused <= cfg_wdata[CMD_W-1];
            end else begin
                base_q <= cfg_wdata;
            end
        end
    end

    // Purpose: mark the unused bits between the mask and the shift field.
    generate
        if (SHIFT_POS > QID_W) begin : g_gap
            assign gap_unused = ^cfg_wdata[SHIFT_POS-1:QID_W];
        end else begin : g_nogap
            assign gap_unused = 1'b0;
        end
    endgenerate

    // Purpose: the mask plus one must be a power of two (contiguous low ones).
    always_comb mask_inc = mask_q + 1'b1;

    // Purpose: flag a zero base, a base wider than the queue field, or a bad mask.
    always_comb begin
        cfg_err = (base_q == '0)
               || (base_q[CMD_W-1 -: BASE_HI_W] != '0)
               || ((mask_q & mask_inc) != '0);
    end

    assign shift_amt   = shift_q;
    assign spread_mask = mask_q;
    assign qbase       = base_q[QID_W-1:0];
    assign cmd_zero    = (shift_q == '0) && (mask_q == '0) && !sym_q;
    assign sym_mode    = sym_q;

    p_sym_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == SEL_HASHCMD) |=> (sym_mode == $past(cfg_wdata[SYM_POS])));

    p_zero_base_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == SEL_QBASE && cfg_wdata == '0) |=> cfg_err);

    p_wide_base_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == SEL_QBASE && cfg_wdata[CMD_W-1 -: BASE_HI_W] != '0) |=> cfg_err);
endmodule

// File: rtl/flowq_qid_calc.sv
// Module: combinational queue number computation.
// Shifts the hash right, keeps the low queue-width bits, masks and adds the base.
// Assumes the mask has already been checked by the configuration store.
module flowq_qid_calc #(
    parameter int HASH_W  = 64,
    parameter int QID_W   = 24,
    parameter int SHIFT_W = 6
) (
    input  logic [HASH_W-1:0]  hash,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic [QID_W-1:0]   spread_mask,
    input  logic [QID_W-1:0]   qbase,
    output logic [QID_W-1:0]   qid
);
    logic [HASH_W-1:0]       shifted;
    logic [QID_W-1:0]        window;
    logic [QID_W-1:0]        offset;
    logic [HASH_W-QID_W-1:0] upper_unused;

    // Purpose: align the selected hash bits to the bottom.
    always_comb shifted = hash >> shift_amt;

    // Purpose: keep the queue-width window and discard the rest.
    always_comb begin
        window       = shifted[QID_W-1:0];
        upper_unused = shifted[HASH_W-1:QID_W];
    end

    // Purpose: limit to the spread range and offset from the base, wrapping.
    always_comb begin
        offset = window & spread_mask;
        qid    = qbase + offset;
    end

    // Purpose: a zero mask must give the base itself.
    always_comb begin
        if (spread_mask == '0) begin
            p_zero_mask_base_r4: assert (qid == qbase);
        end
    end
endmodule

// File: rtl/flowq_out_stage.sv
// Module: one-entry registered output stage with valid/ready on both sides.
// Accepts when empty or when the held entry drains in the same cycle.
module flowq_out_stage #(
    parameter int QID_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [QID_W-1:0] in_qid,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [QID_W-1:0] out_qid
);
    logic             vld_q;
    logic [QID_W-1:0] qid_q;

    // Purpose: accept whenever the slot is free or being emptied.
    always_comb in_ready = !vld_q || out_ready;

    // Purpose: load or drain the single output slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            qid_q <= '0;
        end else if (in_ready) begin
            vld_q <= in_valid;
            if (in_valid) begin
                qid_q <= in_qid;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_qid   = qid_q;

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_qid)));

    p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_qid == $past(in_qid)));

    p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/flowq_spread.sv
// Module: top of the hash-based queue distributor.
// Joins configuration store, queue computation and output register.
// Assumes the caller supplies the flow hash; no key extraction here.
module flowq_spread
    import flowq_pkg::*;
#(
    parameter int HASH_W  = 64,
    parameter int QID_W   = 24,
    parameter int SHIFT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [CMD_W-1:0]  cfg_wdata,
    output logic              cfg_err,
    output logic              sym_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HASH_W-1:0] in_hash,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [QID_W-1:0]  out_qid
);
    logic [SHIFT_W-1:0] shift_amt;
    logic [QID_W-1:0]   spread_mask;
    logic [QID_W-1:0]   qbase;
    logic               cmd_zero;
    logic [QID_W-1:0]   next_qid;

    flowq_cfg_regs #(
        .QID_W   (QID_W),
        .SHIFT_W (SHIFT_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .shift_amt   (shift_amt),
        .spread_mask (spread_mask),
        .qbase       (qbase),
        .cmd_zero    (cmd_zero),
        .sym_mode    (sym_mode),
        .cfg_err     (cfg_err)
    );

    flowq_qid_calc #(
        .HASH_W  (HASH_W),
        .QID_W   (QID_W),
        .SHIFT_W (SHIFT_W)
    ) u_calc (
        .hash        (in_hash),
        .shift_amt   (shift_amt),
        .spread_mask (spread_mask),
        .qbase       (qbase),
        .qid         (next_qid)
    );

    flowq_out_stage #(
        .QID_W (QID_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_qid    (next_qid),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_qid   (out_qid)
    );

    p_disabled_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cmd_zero) |=> (out_qid == $past(qbase)));
endmodule

// File: tb/tb_flowq_spread.sv
module tb_flowq_spread;
    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] base;
        logic [63:0] hash;
        logic [23:0] qid;
        logic        sym;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h0000_0100, 64'hDEAD_BEEF_1234_5678, 24'h000100, 1'b0}, // R4
        '{32'h0000_000F, 32'h0000_0100, 64'hDEAD_BEEF_1234_5678, 24'h000108, 1'b0}, // R3
        '{32'h0400_00FF, 32'h0000_1000, 64'h0000_0000_0000_0ABC, 24'h0010AB, 1'b0}, // R2
        '{32'h2000_0FFF, 32'h0040_0000, 64'h0000_0123_0000_0000, 24'h400123, 1'b0}, // R2
        '{32'h3F00_0001, 32'h0000_0002, 64'h8000_0000_0000_0000, 24'h000003, 1'b0}, // R2
        '{32'h4000_0003, 32'h0000_0010, 64'h0000_0000_0000_0007, 24'h000013, 1'b1}, // R5
        '{32'h8000_0007, 32'h0000_0008, 64'h0000_0000_0000_0005, 24'h00000D, 1'b0}, // R10
        '{32'h00FF_FFFF, 32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 24'h000000, 1'b0}, // R9
        '{32'h08FF_FFFF, 32'h0000_0001, 64'h0000_0000_1234_5678, 24'h123457, 1'b0}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_err;
    logic        sym_mode;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_hash = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_qid;

    int applied = 0;
    int misses = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flowq_spread dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_err   (cfg_err),
        .sym_mode  (sym_mode),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_hash   (in_hash),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_qid   (out_qid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one hash for one edge; return at the negedge after it.
    task automatic push(input logic [63:0] h);
        @(negedge clk);
        in_valid = 1'b1; in_hash = h;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
        chk("R1 sym_mode", {31'b0, sym_mode}, 32'd0);
        chk("R1 cfg_err", {31'b0, cfg_err}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            wr(1'b0, VECS[i].cmd);
            wr(1'b1, VECS[i].base);
            push(VECS[i].hash);
            chk("R7 valid after accept", {31'b0, out_valid}, 32'd1);
            chk($sformatf("R2 vector %0d qid", i), {8'b0, out_qid}, {8'b0, VECS[i].qid});
            chk($sformatf("R5 vector %0d sym", i), {31'b0, sym_mode}, {31'b0, VECS[i].sym});
            chk($sformatf("R10 vector %0d err", i), {31'b0, cfg_err}, 32'd0);
            @(negedge clk);
            chk("R7 drained", {31'b0, out_valid}, 32'd0);
        end

        // R4: a second hash with the command word cleared still hits the base
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0000_0777);
        push(64'h0123_4567_89AB_CDEF);
        chk("R4 disabled hashing", {8'b0, out_qid}, 32'h0000_0777);
        @(negedge clk);

        // R6: configuration error cases
        wr(1'b1, 32'h0);
        chk("R6 zero base", {31'b0, cfg_err}, 32'd1);
        wr(1'b1, 32'h0100_0000);
        chk("R6 base above 24 bits", {31'b0, cfg_err}, 32'd1);
        wr(1'b1, 32'h00FF_FFFF);
        chk("R6 max base ok", {31'b0, cfg_err}, 32'd0);
        wr(1'b0, 32'h0000_0005);
        chk("R6 mask not contiguous", {31'b0, cfg_err}, 32'd1);
        wr(1'b0, 32'h0000_0007);
        chk("R6 contiguous mask", {31'b0, cfg_err}, 32'd0);
        wr(1'b0, 32'h8000_0005);
        chk("R10 reserved bit keeps error", {31'b0, cfg_err}, 32'd1);

        // R8: backpressure holds the output and blocks input
        wr(1'b0, 32'h0000_00FF);
        wr(1'b1, 32'h0000_0100);
        out_ready = 1'b0;
        push(64'h0000_0000_0000_0011);
        chk("R8 first held", {8'b0, out_qid}, 32'h0000_0111);
        in_valid = 1'b1; in_hash = 64'h0000_0000_0000_0022;
        #1;
        chk("R8 in_ready low", {31'b0, in_ready}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R8 valid held", {31'b0, out_valid}, 32'd1);
        chk("R8 qid stable", {8'b0, out_qid}, 32'h0000_0111);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 replaced on drain", {8'b0, out_qid}, 32'h0000_0122);
        chk("R7 valid on replace", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        chk("R7 empty after drain", {31'b0, out_valid}, 32'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end
endmodule